// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a logical address into a physical one in two stages. The address carries a segment number in its top bits and a byte offset below that. The block first reads a two-word segment descriptor from memory. The descriptor holds the base of that segment's page table, a byte limit, a valid flag and access rights. The block then reads one page-table entry, indexed by the page field of the offset, and joins the frame number it holds with the in-page offset.

Bounds and rights are checked from the descriptor before any paging is done. Because of this, an access past the true end of a segment faults even when it falls inside the last allocated page. All table reads go through a single memory read port. They are issued one at a time and nothing is cached. A request is accepted while `req_ready` is high. The result is given in a one-cycle `done` pulse, which carries either the physical address or a fault code.

The controller is a state machine with eight named states:
- ST_IDLE: waits for a request and checks the segment range.
- ST_BASE_REQ and ST_BASE_WAIT: read the page-table base word.
- ST_FLAG_REQ and ST_FLAG_WAIT: read the limit-and-rights word and check it.
- ST_PTE_REQ and ST_PTE_WAIT: read the page-table entry.
- ST_FINISH: presents the result.

Its transitions are:
- ST_IDLE goes to ST_FINISH on a range fault, and to ST_BASE_REQ otherwise.
- Each request state goes to its wait state.
- Each wait state moves on when read data returns.
- ST_FLAG_WAIT goes to ST_FINISH on a descriptor fault.
- ST_FINISH always returns to ST_IDLE.

Top module: `seg_page_xlat`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1 and both `done` and `mem_rd_en` are 0.
- R2: Fields of `laddr`: segment = bits 31:28, page index = bits 27:12, in-page offset = bits 11:0. The offset checked against the limit is bits 27:0. On success, `phys_addr` = {PTE bits 19:0, laddr bits 11:0}, `fault` is 0 and `fault_code` is 0.
- R3: If the segment number is not below `seg_len`, the result is fault code 1. No memory read is issued, and `done` rises in the cycle right after acceptance.
- R4: The descriptor is read as two words. The first is at `seg_base` + 2·segment and holds the page-table base. The second is at `seg_base` + 2·segment + 1 and holds: bit 31 valid, bit 30 execute allowed, bit 29 write allowed, bit 28 read allowed, bits 27:0 limit in bytes.
- R5: If the descriptor valid bit is 0, the result is fault code 2.
- R6: If the offset (bits 27:0) is equal to or above the limit, the result is fault code 3, even when the page-table entry for that page is valid.
- R7: The access type is 0 for read, 1 for write, 2 for execute and 3 for reserved. Each of the first three needs its matching rights bit, and type 3 is always refused. A refused access gives fault code 4.
- R8: The page-table entry is read at page-table base + page index. Its bit 31 is the valid flag and bits 19:0 are the frame number. An invalid entry gives fault code 5.
- R9: When several faults apply, the lowest code is reported (1 before 2, 3, 4, then 5). No page-table entry is read after a descriptor fault.
- R10: Only one read is outstanding at a time, and `mem_rd_en` is a one-cycle pulse. `done` is a one-cycle pulse in the cycle after the last read data arrives. `fault` is 1 exactly when the code is non-zero, and `phys_addr` is 0 on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and can take a request |
| seg_base | input | 32 | Word address of the segment table |
| seg_len | input | 5 | Number of segment-table entries |
| laddr | input | 32 | Logical address |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_en | output | 1 | Read request pulse |
| mem_addr | output | 32 | Word address of the read |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | Result pulse |
| fault | output | 1 | Translation fault |
| fault_code | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 rights, 5 page |
| phys_addr | output | 32 | Physical address |

## Verification
Requests are driven on a falling edge, and all outputs are sampled on falling edges. A range fault must show `done` on the first falling edge after the accepting rising edge. Every other result must show `done` one falling edge after the last sampled `mem_rd_valid`. The bench logs when each read strobe arrived and the number of `mem_rd_en` pulses (0, 2 or 3 by fault class), then compares both with what that fault class requires. A reference function builds the expected code and address from the same table contents that the bench memory model serves.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [2:0] {
        FLT_NONE         = 3'd0,
        FLT_SEG_RANGE    = 3'd1,
        FLT_SEG_INVALID  = 3'd2,
        FLT_LIMIT        = 3'd3,
        FLT_PERM         = 3'd4,
        FLT_PAGE_INVALID = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE_REQ,
        ST_BASE_WAIT,
        ST_FLAG_REQ,
        ST_FLAG_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_FINISH
    } state_e;

    localparam int DESC_VALID_BIT = 31;
    localparam int DESC_EXEC_BIT  = 30;
    localparam int DESC_WRITE_BIT = 29;
    localparam int DESC_READ_BIT  = 28;
    localparam int PTE_VALID_BIT  = 31;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import seg_xlat_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SEG_W  = 4,
    parameter int PIDX_W = 16
) (
    input  state_e            st,
    input  logic [AW-1:0]     seg_base,
    input  logic [SEG_W-1:0]  seg,
    input  logic [AW-1:0]     pt_base,
    input  logic [PIDX_W-1:0] pidx,
    output logic [AW-1:0]     mem_addr
);
    localparam int SEG_PAD  = AW - SEG_W - 1;
    localparam int PIDX_PAD = AW - PIDX_W;

    logic [AW-1:0] desc_addr;
    logic [AW-1:0] pidx_ext;

    // each descriptor occupies two words
    assign desc_addr = seg_base + {{SEG_PAD{1'b0}}, seg, 1'b0};
    assign pidx_ext  = {{PIDX_PAD{1'b0}}, pidx};

    always_comb begin
        case (st)
            ST_BASE_REQ: mem_addr = desc_addr;
            ST_FLAG_REQ: mem_addr = desc_addr + AW'(1);
            ST_PTE_REQ:  mem_addr = pt_base + pidx_ext;
            default:     mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/xlat_desc_check.sv
module xlat_desc_check
    import seg_xlat_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LIM_W = 28
) (
    input  logic [DW-1:0]    flags_word,
    input  logic [LIM_W-1:0] offset,
    input  logic [1:0]       acc,
    output fault_e           desc_fault
);
    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = flags_word[DESC_READ_BIT];
            ACC_WRITE: allowed = flags_word[DESC_WRITE_BIT];
            ACC_EXEC:  allowed = flags_word[DESC_EXEC_BIT];
            default:   allowed = 1'b0;
        endcase
    end

    // ordering here fixes the fault priority
    always_comb begin
        if (!flags_word[DESC_VALID_BIT])
            desc_fault = FLT_SEG_INVALID;
        else if (offset >= flags_word[LIM_W-1:0])
            desc_fault = FLT_LIMIT;
        else if (!allowed)
            desc_fault = FLT_PERM;
        else
            desc_fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int PIDX_W  = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int AW      = 32,
    parameter int DW      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [AW-1:0]                seg_base,
    input  logic [SEG_W:0]               seg_len,
    input  logic [SEG_W+PIDX_W+OFF_W-1:0] laddr,
    input  logic [1:0]                   acc_type,
    output logic                         mem_rd_en,
    output logic [AW-1:0]                mem_addr,
    input  logic                         mem_rd_valid,
    input  logic [DW-1:0]                mem_rd_data,
    output logic                         done,
    output logic                         fault,
    output logic [2:0]                   fault_code,
    output logic [FRAME_W+OFF_W-1:0]     phys_addr
);
    localparam int LA_W  = SEG_W + PIDX_W + OFF_W;
    localparam int LIM_W = PIDX_W + OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;

    state_e            state_q, state_d;
    logic [LA_W-1:0]   lad_q;
    logic [1:0]        acc_q;
    logic [AW-1:0]     sbase_q;
    logic [AW-1:0]     ptbase_q;
    logic [PA_W-1:0]   phys_q;
    fault_e            fault_q;
    fault_e            desc_fault;
    logic              seg_oob;

    assign seg_oob = {1'b0, laddr[LA_W-1 -: SEG_W]} >= seg_len;

    xlat_addr_gen #(.AW(AW), .SEG_W(SEG_W), .PIDX_W(PIDX_W)) u_addr (
        .st       (state_q),
        .seg_base (sbase_q),
        .seg      (lad_q[LA_W-1 -: SEG_W]),
        .pt_base  (ptbase_q),
        .pidx     (lad_q[LIM_W-1 -: PIDX_W]),
        .mem_addr (mem_addr)
    );

    xlat_desc_check #(.DW(DW), .LIM_W(LIM_W)) u_chk (
        .flags_word (mem_rd_data),
        .offset     (lad_q[LIM_W-1:0]),
        .acc        (acc_q),
        .desc_fault (desc_fault)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = seg_oob ? ST_FINISH : ST_BASE_REQ;
            ST_BASE_REQ:  state_d = ST_BASE_WAIT;
            ST_BASE_WAIT: if (mem_rd_valid) state_d = ST_FLAG_REQ;
            ST_FLAG_REQ:  state_d = ST_FLAG_WAIT;
            ST_FLAG_WAIT: if (mem_rd_valid)
                              state_d = (desc_fault != FLT_NONE) ? ST_FINISH : ST_PTE_REQ;
            ST_PTE_REQ:   state_d = ST_PTE_WAIT;
            ST_PTE_WAIT:  if (mem_rd_valid) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lad_q    <= '0;
            acc_q    <= '0;
            sbase_q  <= '0;
            ptbase_q <= '0;
            phys_q   <= '0;
            fault_q  <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    lad_q   <= laddr;
                    acc_q   <= acc_type;
                    sbase_q <= seg_base;
                    phys_q  <= '0;
                    fault_q <= seg_oob ? FLT_SEG_RANGE : FLT_NONE;
                end
                ST_BASE_WAIT: if (mem_rd_valid) ptbase_q <= mem_rd_data[AW-1:0];
                ST_FLAG_WAIT: if (mem_rd_valid) fault_q <= desc_fault;
                ST_PTE_WAIT: if (mem_rd_valid) begin
                    if (!mem_rd_data[PTE_VALID_BIT]) fault_q <= FLT_PAGE_INVALID;
                    else phys_q <= {mem_rd_data[FRAME_W-1:0], lad_q[OFF_W-1:0]};
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_FINISH);
        mem_rd_en  = (state_q == ST_BASE_REQ) || (state_q == ST_FLAG_REQ) ||
                     (state_q == ST_PTE_REQ);
        fault      = (fault_q != FLT_NONE);
        fault_code = fault_q;
        phys_addr  = phys_q;
    end

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R3
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && seg_oob) |=>
            (done && fault_code == FLT_SEG_RANGE && !mem_rd_en));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (phys_addr[OFF_W-1:0] == lad_q[OFF_W-1:0]));

    // R10
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (phys_addr == '0));
endmodule

// File: tb/seg_page_xlat_tb.sv
`timescale 1ns/1ps
module seg_page_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] seg_base = '0;
    logic [4:0]  seg_len = '0;
    logic [31:0] laddr = '0;
    logic [1:0]  acc_type = '0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        done;
    logic        fault;
    logic [2:0]  fault_code;
    logic [31:0] phys_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    seg_page_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .seg_base(seg_base), .seg_len(seg_len), .laddr(laddr), .acc_type(acc_type),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .done(done), .fault(fault),
        .fault_code(fault_code), .phys_addr(phys_addr)
    );

    // sparse memory model with two-cycle read latency
    logic [31:0] mem [logic [31:0]];
    logic        pend_q = 1'b0;
    logic [31:0] paddr_q = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        pend_q       <= mem_rd_en;
        paddr_q      <= mem_addr;
        mem_rd_valid <= pend_q;
        mem_rd_data  <= rd(paddr_q);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected {code, phys} from the requirement text
    function automatic logic [34:0] ref_xlat(input logic [31:0] sb, input logic [4:0] sl,
                                             input logic [31:0] la, input logic [1:0] acc);
        logic [31:0] w0, w1, pte;
        logic [3:0]  s;
        logic        ok;
        s = la[31:28];
        if ({1'b0, s} >= sl) return {3'd1, 32'h0};
        w0 = rd(sb + {27'h0, s, 1'b0});
        w1 = rd(sb + {27'h0, s, 1'b0} + 32'd1);
        if (!w1[31]) return {3'd2, 32'h0};
        if (la[27:0] >= w1[27:0]) return {3'd3, 32'h0};
        case (acc)
            2'd0: ok = w1[28];
            2'd1: ok = w1[29];
            2'd2: ok = w1[30];
            default: ok = 1'b0;
        endcase
        if (!ok) return {3'd4, 32'h0};
        pte = rd(w0 + {16'h0, la[27:12]});
        if (!pte[31]) return {3'd5, 32'h0};
        return {3'd0, pte[19:0], la[11:0]};
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic run(input logic [31:0] sb, input logic [4:0] sl,
                       input logic [31:0] la, input logic [1:0] acc, input string tag);
        logic [34:0] exp;
        int cyc, lastv, dcyc, reads, exp_reads;
        string rq;
        exp = ref_xlat(sb, sl, la, acc);
        rq  = req_of(exp[34:32]);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        seg_base = sb; seg_len = sl; laddr = la; acc_type = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; lastv = -1; dcyc = -1; reads = 0;
        for (int i = 0; i < 100; i++) begin
            if (mem_rd_en) reads++;
            if (mem_rd_valid) lastv = cyc;
            if (done) begin
                dcyc = cyc;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        chk(dcyc >= 0, "R10", {tag, " done seen"}, 64'(dcyc), 64'(1));
        if (dcyc < 0) return;
        chk(fault_code == exp[34:32], rq, {tag, " fault code"}, 64'(fault_code), 64'(exp[34:32]));
        chk(phys_addr == exp[31:0], rq, {tag, " phys addr"}, 64'(phys_addr), 64'(exp[31:0]));
        chk(fault == (exp[34:32] != 3'd0), "R10", {tag, " fault flag"}, 64'(fault), 64'(exp[34:32] != 0));
        case (exp[34:32])
            3'd0, 3'd5: exp_reads = 3;
            3'd1: exp_reads = 0;
            default: exp_reads = 2;
        endcase
        chk(reads == exp_reads, "R4", {tag, " read count (R9 no PTE after desc fault)"},
            64'(reads), 64'(exp_reads));
        if (exp[34:32] == 3'd1)
            chk(dcyc == 1, "R3", {tag, " done latency"}, 64'(dcyc), 64'(1));
        else
            chk(dcyc == lastv + 1, "R10", {tag, " done latency"}, 64'(dcyc), 64'(lastv + 1));
    endtask

    localparam logic [31:0] SB = 32'h100;

    task automatic set_desc(input int s, input logic [31:0] ptb, input logic [31:0] flags);
        mem[SB + 32'(2 * s)]     = ptb;
        mem[SB + 32'(2 * s + 1)] = flags;
    endtask

    task automatic build_tables();
        for (int s = 0; s < 16; s++) begin
            logic [31:0] ptb, fl;
            ptb = 32'h10000 * 32'(s + 1);
            fl  = {($urandom % 8) != 0, 3'($urandom), 28'($urandom % (8 * 4096 + 2048))};
            set_desc(s, ptb, fl);
            for (int p = 0; p < 8; p++)
                mem[ptb + 32'(p)] = {($urandom % 6) != 0, 11'h0, 20'($urandom)};
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_tables();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !done && !mem_rd_en, "R1", "in reset", 64'({req_ready, done, mem_rd_en}), 64'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_rd_en, "R1", "after reset", 64'({req_ready, done, mem_rd_en}), 64'(3'b100));

        // R3 range corners
        run(SB, 5'd0, 32'h0000_0000, 2'd0, "R3 len zero");
        run(SB, 5'd15, 32'hF000_0010, 2'd0, "R3 seg equals len");
        set_desc(14, 32'h0F_0000, {4'b1111, 28'h10_0000});
        mem[32'h0F_0000] = {1'b1, 11'h0, 20'hABCDE};
        run(SB, 5'd15, 32'hE000_0123, 2'd0, "R2 last legal seg");

        // R6 limit inside the last page
        set_desc(2, 32'h30000, {4'b1111, 28'h1800});
        mem[32'h30000] = {1'b1, 11'h0, 20'h00111};
        mem[32'h30001] = {1'b1, 11'h0, 20'h00222};
        run(SB, 5'd16, 32'h2000_17FF, 2'd0, "R6 offset limit-1");
        run(SB, 5'd16, 32'h2000_1800, 2'd0, "R6 offset at limit");
        run(SB, 5'd16, 32'h2000_1000, 2'd1, "R2 second page");

        // R9 invalid wins over limit
        set_desc(3, 32'h40000, {4'b0111, 28'h0});
        run(SB, 5'd16, 32'h3000_5000, 2'd0, "R9 invalid over limit");

        // R7 rights and R9 rights over page
        set_desc(4, 32'h50000, {4'b1001, 28'h10_0000});
        mem[32'h50005] = {1'b0, 11'h0, 20'h00777};
        mem[32'h50001] = {1'b1, 11'h0, 20'h00999};
        run(SB, 5'd16, 32'h4000_1004, 2'd1, "R7 write refused");
        run(SB, 5'd16, 32'h4000_1004, 2'd2, "R7 exec refused");
        run(SB, 5'd16, 32'h4000_1004, 2'd3, "R7 reserved type");
        run(SB, 5'd16, 32'h4000_5004, 2'd1, "R9 rights over page");
        run(SB, 5'd16, 32'h4000_5004, 2'd0, "R8 page invalid");
        run(SB, 5'd16, 32'h4000_1FFF, 2'd0, "R8 valid page");

        // random phase
        build_tables();
        for (int k = 0; k < 80; k++) begin
            logic [31:0] la;
            logic [4:0]  sl;
            la = {4'($urandom % 16), 16'($urandom % 9), 12'($urandom)};
            sl = ($urandom % 4 == 0) ? 5'($urandom % 17) : 5'd16;
            run(SB, sl, la, 2'($urandom), "random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule